// File: doc/BRIEF.md
# Timer DMA Burst Register Window

This block lets a hardware event inside a general-purpose timer move a run of consecutive timer registers through a single data-port address. Software writes a burst control register holding a base word index and a transfer count, then sets the DMA request enable for one or more event sources. When an enabled event fires, the block raises a request toward a DMA engine. Each acknowledge from that engine steps an internal index, so the data port shows the next register of the run. After the final transfer the request drops.

The timer's counting logic is not part of this block. A word-addressed register file stands in for it. The DMA controller is reduced to a one-wire acknowledge: the transfer happens in the cycle that `dma_ack_i` is high while `dma_req_o` is high. Events that arrive while a burst is running are held as one pending request. That request starts a fresh burst from the base index once the running one ends.

Top module: `timer_dma_burst`

## Requirements
- R1: After reset, `dma_req_o` is 0 and the burst control, event-flag and enable registers all read 0.
- R2: The burst control register sits at byte offset 0x48. Its bits 4:0 are the base word index (byte offset divided by four) and its bits 12:8 are the transfer count minus one. All other bits read as 0.
- R3: A burst makes exactly count+1 transfers. `dma_req_o` stays high until the acknowledge of the last transfer, and it is low in the cycle after that acknowledge.
- R4: `dma_rdata_o`, and a bus read of offset 0x4C, return the register at base+index. The index starts at 0 and moves up by one per acknowledge. Without an acknowledge the index holds.
- R5: The enable register at offset 0x0C holds the DMA request enables in bits 8..14. `evt_i` bit j (0 = update, 1..4 = capture/compare 1..4, 5 = commutation, 6 = trigger) starts a burst only when enable bit 8+j is set. An event whose enable is clear leaves `dma_req_o` low.
- R6: The event-flag register at offset 0x10 sets bit j on every `evt_i[j]` pulse, whether or not it is enabled. A write keeps only the flags whose written bit is 1, so writing 0 clears all flags.
- R7: An enabled event that arrives during a burst is held as one pending request, and further events during that burst add nothing. After the last acknowledge, `dma_req_o` is low for exactly one cycle. It then rises with the index at 0.
- R8: A write to the burst control register puts the index back to 0 without ending a running burst. The data port then shows the register at the new base.
- R9: Bus writes to other word-aligned offsets are stored and read back. Writes to the data port at 0x4C, and writes whose byte address is not a multiple of four, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | AW (8) | Register byte address |
| bus_wdata_i | input | DW (32) | Register write data |
| bus_rdata_o | output | DW (32) | Register read data, combinational from `bus_addr_i` |
| evt_i | input | NEVT (7) | Timer event pulses, one per source |
| dma_req_o | output | 1 | DMA request |
| dma_ack_i | input | 1 | DMA acknowledge; one transfer per cycle high |
| dma_rdata_o | output | DW (32) | Word currently shown at the data port |

## Verification
An event or acknowledge that is sampled on a rising edge shows on `dma_req_o` and on the data port one cycle later. A register write also takes effect one cycle later. Bus reads and the data port word are combinational from the current state. A pending burst restarts two cycles after the final acknowledge: the first cycle has the request low, and the second has it high again. The bench drives all inputs and samples all outputs on the falling edge that follows the edge where a change is due. It keeps acknowledges high for exact counts, so every transfer of a burst is compared against the word that the bench itself wrote at base+index. The sweep covers all bases from 20 to 31 with counts of 0, 1, 5 and 31.

// File: rtl/tdb_pkg.sv
package tdb_pkg;
  localparam int unsigned DIER_OFS = 'h0C;
  localparam int unsigned SR_OFS   = 'h10;
  localparam int unsigned DCR_OFS  = 'h48;
  localparam int unsigned DMAR_OFS = 'h4C;
  localparam int unsigned EN_LSB   = 8;
  localparam int unsigned FLD_W    = 5;

  typedef struct packed {
    logic [FLD_W-1:0] len;
    logic [FLD_W-1:0] base;
  } dcr_t;
endpackage

// File: rtl/tdb_regs.sv
module tdb_regs #(
  parameter int unsigned NWORDS = 64,
  parameter int unsigned DW     = 32,
  localparam int unsigned IW    = $clog2(NWORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_a_i,
  input  logic [IW-1:0] ridx_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem_q [NWORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NWORDS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[ridx_a_i];
  assign rdata_b_o = mem_q[ridx_b_i];
endmodule

// File: rtl/tdb_evt.sv
module tdb_evt
  import tdb_pkg::*;
#(
  parameter int unsigned NEVT = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEVT-1:0] evt_i,
  input  logic            dier_we_i,
  input  logic [15:0]     dier_wdata_i,
  input  logic            sr_we_i,
  input  logic [NEVT-1:0] sr_wdata_i,
  output logic [15:0]     dier_o,
  output logic [NEVT-1:0] sr_o,
  output logic            trig_o
);
  logic [15:0]     dier_q;
  logic [NEVT-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dier_q <= '0;
    else if (dier_we_i) dier_q <= dier_wdata_i;
  end

  for (genvar g = 0; g < NEVT; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[g] <= 1'b0;
      else if (evt_i[g]) sr_q[g] <= 1'b1;
      else if (sr_we_i) sr_q[g] <= sr_q[g] & sr_wdata_i[g];
    end
  end

  assign trig_o = |(evt_i & dier_q[EN_LSB +: NEVT]);
  assign dier_o = dier_q;
  assign sr_o   = sr_q;

  assert_sr_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |evt_i |=> ((sr_q & $past(evt_i)) == $past(evt_i)));
  assert_sr_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_we_i && sr_wdata_i == '0 && evt_i == '0) |=> sr_q == '0);
endmodule

// File: rtl/tdb_seq.sv
module tdb_seq
  import tdb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dcr_we_i,
  input  dcr_t             dcr_wdata_i,
  input  logic             trig_i,
  input  logic             ack_i,
  output dcr_t             dcr_o,
  output logic [FLD_W-1:0] idx_o,
  output logic             req_o
);
  dcr_t             dcr_q;
  logic [FLD_W-1:0] idx_q;
  logic             busy_q, pend_q;
  logic             last_ack;

  assign last_ack = busy_q && ack_i && (idx_q == dcr_q.len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dcr_q <= '0;
    else if (dcr_we_i) dcr_q <= dcr_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      if (!busy_q) begin
        if (trig_i || pend_q) begin
          busy_q <= 1'b1;
          pend_q <= 1'b0;
          idx_q  <= '0;
        end
      end else begin
        if (trig_i) pend_q <= 1'b1;
        if (last_ack) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else if (ack_i) begin
          idx_q <= idx_q + 1'b1;
        end
      end
      if (dcr_we_i) idx_q <= '0;
    end
  end

  assign dcr_o = dcr_q;
  assign idx_o = idx_q;
  assign req_o = busy_q;

  assert_req_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_ack |=> !req_o);
  assert_idx_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> idx_q <= dcr_q.len);
  assert_idx_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ack_i && !last_ack && !dcr_we_i) |=> idx_q == $past(idx_q) + 1'b1);
  assert_idx_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ack_i && !dcr_we_i) |=> $stable(idx_q));
  assert_no_spurious_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !trig_i && !pend_q) |=> !req_o);
  assert_pend_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && pend_q) |=> (req_o && idx_q == '0));
  assert_dcr_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcr_we_i |=> idx_q == '0);
endmodule

// File: rtl/timer_dma_burst.sv
module timer_dma_burst
  import tdb_pkg::*;
#(
  parameter int unsigned NWORDS = 64,
  parameter int unsigned DW     = 32,
  parameter int unsigned NEVT   = 7,
  localparam int unsigned WIW   = $clog2(NWORDS),
  localparam int unsigned AW    = WIW + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_we_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  input  logic [NEVT-1:0] evt_i,
  output logic            dma_req_o,
  input  logic            dma_ack_i,
  output logic [DW-1:0]   dma_rdata_o
);
  localparam logic [WIW-1:0] DIER_I = WIW'(DIER_OFS / 4);
  localparam logic [WIW-1:0] SR_I   = WIW'(SR_OFS / 4);
  localparam logic [WIW-1:0] DCR_I  = WIW'(DCR_OFS / 4);
  localparam logic [WIW-1:0] DMAR_I = WIW'(DMAR_OFS / 4);

  logic [WIW-1:0]   bus_idx, win_idx;
  logic             wr_ok, special;
  logic [15:0]      dier;
  logic [NEVT-1:0]  sr;
  logic             trig;
  dcr_t             dcr;
  logic [FLD_W-1:0] idx;
  logic [DW-1:0]    rd_a, rd_b, dcr_word, dier_word, sr_word;

  assign bus_idx = bus_addr_i[AW-1:2];
  assign wr_ok   = bus_we_i && (bus_addr_i[1:0] == 2'b00);
  assign special = (bus_idx == DIER_I) || (bus_idx == SR_I) ||
                   (bus_idx == DCR_I)  || (bus_idx == DMAR_I);
  assign win_idx = WIW'(dcr.base) + WIW'(idx);

  tdb_regs #(.NWORDS(NWORDS), .DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_ok && !special),
    .widx_i    (bus_idx),
    .wdata_i   (bus_wdata_i),
    .ridx_a_i  (bus_idx),
    .ridx_b_i  (win_idx),
    .rdata_a_o (rd_a),
    .rdata_b_o (rd_b)
  );

  tdb_evt #(.NEVT(NEVT)) u_evt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt_i),
    .dier_we_i    (wr_ok && bus_idx == DIER_I),
    .dier_wdata_i (bus_wdata_i[15:0]),
    .sr_we_i      (wr_ok && bus_idx == SR_I),
    .sr_wdata_i   (bus_wdata_i[NEVT-1:0]),
    .dier_o       (dier),
    .sr_o         (sr),
    .trig_o       (trig)
  );

  tdb_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dcr_we_i    (wr_ok && bus_idx == DCR_I),
    .dcr_wdata_i ({bus_wdata_i[8 +: FLD_W], bus_wdata_i[0 +: FLD_W]}),
    .trig_i      (trig),
    .ack_i       (dma_ack_i),
    .dcr_o       (dcr),
    .idx_o       (idx),
    .req_o       (dma_req_o)
  );

  assign dcr_word  = DW'({dcr.len, 3'b000, dcr.base});
  assign dier_word = DW'(dier);
  assign sr_word   = DW'(sr);

  always_comb begin
    case (win_idx)
      DIER_I:  dma_rdata_o = dier_word;
      SR_I:    dma_rdata_o = sr_word;
      DCR_I:   dma_rdata_o = dcr_word;
      DMAR_I:  dma_rdata_o = '0;
      default: dma_rdata_o = rd_b;
    endcase
  end

  always_comb begin
    case (bus_idx)
      DIER_I:  bus_rdata_o = dier_word;
      SR_I:    bus_rdata_o = sr_word;
      DCR_I:   bus_rdata_o = dcr_word;
      DMAR_I:  bus_rdata_o = dma_rdata_o;
      default: bus_rdata_o = rd_a;
    endcase
  end

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !dma_req_o);
  assert_dmar_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && bus_idx == DMAR_I && !dma_ack_i && !evt_i) |=> $stable(dma_rdata_o));
endmodule

// File: tb/timer_dma_burst_tb.sv
module timer_dma_burst_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  evt = '0;
  logic        dma_req;
  logic        dma_ack = 1'b0;
  logic [31:0] dma_rdata;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  timer_dma_burst u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .evt_i(evt),
    .dma_req_o(dma_req), .dma_ack_i(dma_ack), .dma_rdata_o(dma_rdata)
  );

  function automatic logic [31:0] pat(int k);
    return 32'h5A00_0000 | (32'(k) << 12) | 32'(k * 3 + 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(string tag, logic [7:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    @(negedge clk);
  endtask

  task automatic pulse(logic [6:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic run_burst(string tag, int base, int len);
    for (int i = 0; i <= len; i++) begin
      chk({tag, " req"}, 32'(dma_req), 32'd1);
      chk({tag, " data"}, dma_rdata, pat(base + i));
      dma_ack = 1'b1;
      @(negedge clk);
    end
    dma_ack = 1'b0;
    chk({tag, " drop"}, 32'(dma_req), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", 32'(dma_req), 32'd0);
    bus_rd("R1 dcr", 8'h48, 32'h0);
    bus_rd("R1 sr", 8'h10, 32'h0);
    bus_rd("R1 dier", 8'h0C, 32'h0);

    for (int k = 0; k < 64; k++)
      if (k != 3 && k != 4 && k != 18 && k != 19) bus_wr(8'(k * 4), pat(k));

    // R9 storage, data-port and misaligned writes ignored
    bus_rd("R9 word20", 8'(20 * 4), pat(20));
    bus_wr(8'h4C, 32'hDEAD_BEEF);
    bus_rd("R9 dmar wr", 8'h00, pat(0));
    bus_wr(8'(21 * 4 + 2), 32'h1234_5678);
    bus_rd("R9 misaligned", 8'(21 * 4), pat(21));

    // R2 field layout
    bus_wr(8'h48, 32'hFFFF_FFFF);
    bus_rd("R2 mask", 8'h48, 32'h0000_1F1F);
    bus_wr(8'h48, 32'h0000_0014);
    bus_rd("R2 base", 8'h48, 32'h0000_0014);
    bus_rd("R4 bus port", 8'h4C, pat(20));

    // R5 disabled events do nothing, R6 flags
    pulse(7'h7F);
    chk("R5 all disabled", 32'(dma_req), 32'd0);
    @(negedge clk);
    chk("R5 all disabled", 32'(dma_req), 32'd0);
    bus_rd("R6 flags set", 8'h10, 32'h7F);
    bus_wr(8'h10, 32'h7B);
    bus_rd("R6 partial clear", 8'h10, 32'h7B);
    bus_wr(8'h10, 32'h0);
    bus_rd("R6 clear all", 8'h10, 32'h0);

    // R5 each source enable
    for (int j = 0; j < 7; j++) begin
      bus_wr(8'h0C, 32'(1) << (8 + j));
      pulse(7'h7F & ~(7'(1) << j));
      chk("R5 other sources", 32'(dma_req), 32'd0);
      pulse(7'(1) << j);
      run_burst("R5 source", 20, 0);
    end

    // R3 and R4 sweep
    bus_wr(8'h0C, 32'h200);
    for (int b = 20; b < 32; b++) begin
      for (int s = 0; s < 4; s++) begin
        int len;
        len = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 5 : 31;
        bus_wr(8'h48, 32'((len << 8) | b));
        pulse(7'h02);
        run_burst("R3 sweep", b, len);
      end
    end

    // R4 index holds without acknowledge
    bus_wr(8'h48, 32'h0000_0216);
    pulse(7'h02);
    for (int i = 0; i < 3; i++) begin
      chk("R4 hold", dma_rdata, pat(22));
      bus_rd("R4 hold bus", 8'h4C, pat(22));
    end
    run_burst("R4 after hold", 22, 2);

    // R7 pending event during burst
    bus_wr(8'h48, 32'h0000_0214);
    pulse(7'h02);
    chk("R7 req", 32'(dma_req), 32'd1);
    chk("R7 data", dma_rdata, pat(20));
    dma_ack = 1'b1; evt = 7'h02;
    @(negedge clk);
    evt = 7'h02;
    chk("R7 data", dma_rdata, pat(21));
    @(negedge clk);
    evt = '0;
    chk("R7 data", dma_rdata, pat(22));
    @(negedge clk);
    dma_ack = 1'b0;
    chk("R7 gap", 32'(dma_req), 32'd0);
    @(negedge clk);
    run_burst("R7 restart", 20, 2);
    @(negedge clk);
    chk("R7 single pending", 32'(dma_req), 32'd0);

    // R8 control write mid-burst
    bus_wr(8'h48, 32'h0000_0319);
    pulse(7'h02);
    dma_ack = 1'b1;
    @(negedge clk);
    @(negedge clk);
    dma_ack = 1'b0;
    chk("R8 mid", dma_rdata, pat(27));
    bus_wr(8'h48, 32'h0000_0319);
    run_burst("R8 rewind", 25, 3);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule